// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end and operation sequencer of a block-erasable flash device. The host issues bus write cycles, each carrying a byte and the block-select bits of the latched address. From these cycles the block keeps track of what a read returns: array data, the status byte, identifier data or query data. It also accepts two-cycle setup/confirm sequences that start a program, a block erase, a lock-bit set or a clear of all lock bits.

The array algorithms are not built. A programmable cycle counter stands in for each operation and defines its duration. The block holds the status byte with its sticky error flags, one lock bit per block and the write-protect gating. It also handles suspend and resume of erase and program. While an erase is suspended, one program may run in another block. A single input reports whether the programming supply is valid.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_mode_o is 0 (array), status_o is 80H, busy_o is 0 and lock_o is all zero. An asynchronous reset during a running operation aborts it, and a lock-bit set in progress leaves its bit unchanged. Reset also discards a pending setup byte.
- R2: A first-cycle write of FFH selects array reads (rd_mode_o=0). 70H selects status reads (1), 90H selects identifier reads (2) and 98H selects query reads (3). A setup byte (40H, 10H, 20H, 60H) switches to status reads (1).
- R3: 40H or 10H followed by a second write starts a program in the block given by that write. From the edge of the second write, busy_o is 1 and status bit 7 (ready) is 0 for exactly op_cycles_i cycles. Afterwards status_o returns to 80H.
- R4: 20H followed by D0H starts a block erase. A second byte other than D0H starts nothing and sets status bits 5 and 4.
- R5: 60H then 01H sets the addressed block's lock bit when the operation completes. 60H then D0H clears every lock bit at completion. Any other second byte sets status bits 5 and 4. Lock bits change only through these sequences.
- R6: With supply_ok_i low, a program is rejected with status bits 3 and 4 set. An erase is rejected with bits 3 and 5 set.
- R7: With unlock_en_i low, the following are rejected: a program to a locked block (bits 1 and 4), an erase of a locked block (bits 1 and 5), a lock-bit set (bits 1 and 4) and a lock-bit clear (bits 1 and 5). With unlock_en_i high, all four proceed.
- R8: Status bits 5, 4, 3 and 1 are sticky. Only 50H clears them, and 50H is ignored while an operation runs or is suspended.
- R9: B0H during an erase suspends it SUSP_LAT cycles after the write edge, giving status bits 7 and 6 set. B0H during a program gives bits 7 and 2 set. D0H resumes, clears those bits and the operation completes. Array and identifier reads may be selected while suspended.
- R10: During an erase suspend, a program may start. While it runs, bit 7 is 0 and bit 6 stays 1. D0H written during that program is ignored.
- R11: While an operation runs unsuspended, every first-cycle byte except 70H and B0H is ignored. In particular, FFH does not return to array reads.
- R12: An unrecognised first-cycle byte changes neither the read mode nor the status byte.
- R13: A suspend request written on the same edge at which an operation completes is dropped. The operation completes, and no suspend bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| blk_addr_i | input | BLK_W | Block-select bits of the write address |
| wr_data_i | input | 8 | Command or data byte |
| supply_ok_i | input | 1 | Programming supply valid |
| unlock_en_i | input | 1 | 1 lets locked blocks be altered and lock bits be changed |
| op_cycles_i | input | CNT_W | Operation duration in cycles (0 treated as 1) |
| rd_mode_o | output | 2 | Read mode: 0 array, 1 status, 2 identifier, 3 query |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | An operation is running unsuspended |
| lock_o | output | 2**BLK_W | Per-block lock bits |

## Verification
A host write and the end of an operation can land on the same clock edge. The bench provokes this by placing a B0H write exactly op_cycles_i cycles after an erase confirm. The operation must still finish, and the status byte must read 80H both at once and several cycles later, with no late suspend. A second overlap tests the nested case: D0H is written while the program inside an erase suspend is still running. The erase suspend bit must survive until a later D0H.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_IDENT = 2'd2, RD_QUERY = 2'd3} rd_mode_e;
  typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE, OP_LSET, OP_LCLR} op_kind_e;
  typedef enum logic [1:0] {SU_NONE, SU_PROG, SU_ERASE, SU_LOCK} setup_e;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
  localparam logic [7:0] CMD_PROG_A    = 8'h40;
  localparam logic [7:0] CMD_PROG_B    = 8'h10;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_LOCK      = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET  = 8'h01;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;

  // sticky error vector {erase/clear, program/set, supply, lock}
  localparam logic [3:0] ERR_ERASE_M  = 4'b1000;
  localparam logic [3:0] ERR_PROG_M   = 4'b0100;
  localparam logic [3:0] ERR_SUPPLY_M = 4'b0010;
  localparam logic [3:0] ERR_LOCK_M   = 4'b0001;
endpackage

// File: rtl/fcc_op_timer.sv
module fcc_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             hold_i,
  output logic             active_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign done_o   = active_q && !hold_i && (cnt_q == CNT_W'(1));
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= (len_i == '0) ? CNT_W'(1) : len_i;
    end else if (done_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && !hold_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_cnt_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));
endmodule

// File: rtl/fcc_lock_bank.sv
module fcc_lock_bank #(
  parameter int BLK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_i,
  input  logic                  clr_i,
  input  logic [BLK_W-1:0]      blk_i,
  output logic [(1<<BLK_W)-1:0] lock_o
);
  localparam int NBLK = 1 << BLK_W;

  for (genvar g = 0; g < NBLK; g++) begin : g_lock
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    bit_q <= 1'b0;
      else if (clr_i)                                 bit_q <= 1'b0;
      else if (set_i && (blk_i == BLK_W'(g)))         bit_q <= 1'b1;
    end
    assign lock_o[g] = bit_q;
  end

  p_lock_by_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o != $past(lock_o)) |-> $past(set_i || clr_i));
endmodule

// File: rtl/fcc_sequencer.sv
module fcc_sequencer
  import fcc_pkg::*;
#(
  parameter int BLK_W    = 2,
  parameter int CNT_W    = 8,
  parameter int SUSP_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_nested_i,
  input  op_kind_e         kind_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             susp_req_i,
  input  logic             resume_req_i,
  output logic             prim_active_o,
  output logic             prim_susp_o,
  output logic             nested_active_o,
  output logic             esusp_o,
  output logic             psusp_o,
  output logic             can_susp_o,
  output logic             lock_set_o,
  output logic             lock_clr_o,
  output logic [BLK_W-1:0] lock_blk_o
);
  localparam int LAT_W = $clog2(SUSP_LAT + 1);

  op_kind_e         kind_q;
  logic [BLK_W-1:0] blk_q;
  logic             pend_q, susp_q;
  logic [LAT_W-1:0] lat_q;
  logic             prim_active, prim_done, nest_active, nest_done;

  fcc_op_timer #(.CNT_W(CNT_W)) u_prim_timer (
    .clk_i, .rst_ni, .start_i(start_i), .len_i(len_i), .hold_i(susp_q),
    .active_o(prim_active), .done_o(prim_done)
  );

  fcc_op_timer #(.CNT_W(CNT_W)) u_nest_timer (
    .clk_i, .rst_ni, .start_i(start_nested_i), .len_i(len_i), .hold_i(1'b0),
    .active_o(nest_active), .done_o(nest_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= OP_NONE;
      blk_q  <= '0;
      pend_q <= 1'b0;
      susp_q <= 1'b0;
      lat_q  <= '0;
    end else if (start_i) begin
      kind_q <= kind_i;
      blk_q  <= blk_i;
      pend_q <= 1'b0;
      susp_q <= 1'b0;
    end else if (prim_done) begin
      // completion wins over a suspend request on the same edge
      kind_q <= OP_NONE;
      pend_q <= 1'b0;
      susp_q <= 1'b0;
    end else if (susp_req_i && can_susp_o) begin
      pend_q <= 1'b1;
      lat_q  <= LAT_W'(SUSP_LAT);
    end else if (pend_q) begin
      if (lat_q <= LAT_W'(1)) begin
        susp_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        lat_q <= lat_q - LAT_W'(1);
      end
    end else if (resume_req_i && !nest_active) begin
      susp_q <= 1'b0;
    end
  end

  assign prim_active_o   = prim_active;
  assign prim_susp_o     = susp_q;
  assign nested_active_o = nest_active;
  assign esusp_o         = susp_q && (kind_q == OP_ERASE);
  assign psusp_o         = susp_q && (kind_q == OP_PROG);
  assign can_susp_o      = prim_active && !susp_q && !pend_q && !nest_active &&
                           ((kind_q == OP_ERASE) || (kind_q == OP_PROG));
  assign lock_set_o      = prim_done && (kind_q == OP_LSET);
  assign lock_clr_o      = prim_done && (kind_q == OP_LCLR);
  assign lock_blk_o      = blk_q;

  p_nested_in_esusp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nest_active |-> esusp_o);
  p_done_no_susp_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(prim_done) |-> !susp_q);
  p_susp_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> (esusp_o || psusp_o));
  p_nest_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nest_done |=> !nest_active);
endmodule

// File: rtl/fcc_cmd_decoder.sv
module fcc_cmd_decoder
  import fcc_pkg::*;
#(
  parameter int BLK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic [7:0]            data_i,
  input  logic                  supply_ok_i,
  input  logic                  unlock_en_i,
  input  logic [(1<<BLK_W)-1:0] lock_i,
  input  logic                  prim_active_i,
  input  logic                  prim_susp_i,
  input  logic                  nested_active_i,
  input  logic                  esusp_i,
  input  logic                  can_susp_i,
  output rd_mode_e              mode_o,
  output logic                  start_o,
  output logic                  start_nested_o,
  output op_kind_e              start_kind_o,
  output logic                  susp_req_o,
  output logic                  resume_req_o,
  output logic                  clr_err_o,
  output logic [3:0]            err_set_o
);
  rd_mode_e mode_q, mode_d;
  setup_e   pend_q, pend_d;
  logic     running, idle_all, blk_locked;

  assign running    = (prim_active_i && !prim_susp_i) || nested_active_i;
  assign idle_all   = !prim_active_i && !nested_active_i;
  assign blk_locked = lock_i[blk_i];

  always_comb begin
    mode_d         = mode_q;
    pend_d         = pend_q;
    start_o        = 1'b0;
    start_nested_o = 1'b0;
    start_kind_o   = OP_NONE;
    susp_req_o     = 1'b0;
    resume_req_o   = 1'b0;
    clr_err_o      = 1'b0;
    err_set_o      = '0;
    if (wr_i) begin
      if (pend_q != SU_NONE) begin
        pend_d = SU_NONE;
        case (pend_q)
          SU_PROG: begin
            if (!supply_ok_i)                    err_set_o = ERR_SUPPLY_M | ERR_PROG_M;
            else if (blk_locked && !unlock_en_i) err_set_o = ERR_LOCK_M | ERR_PROG_M;
            else begin
              start_kind_o = OP_PROG;
              if (esusp_i) start_nested_o = 1'b1;
              else         start_o        = 1'b1;
            end
          end
          SU_ERASE: begin
            if (data_i != CMD_CONFIRM)           err_set_o = ERR_ERASE_M | ERR_PROG_M;
            else if (!supply_ok_i)               err_set_o = ERR_SUPPLY_M | ERR_ERASE_M;
            else if (blk_locked && !unlock_en_i) err_set_o = ERR_LOCK_M | ERR_ERASE_M;
            else begin
              start_kind_o = OP_ERASE;
              start_o      = 1'b1;
            end
          end
          SU_LOCK: begin
            if (data_i == CMD_LOCK_SET) begin
              if (!supply_ok_i)      err_set_o = ERR_SUPPLY_M | ERR_PROG_M;
              else if (!unlock_en_i) err_set_o = ERR_LOCK_M | ERR_PROG_M;
              else begin
                start_kind_o = OP_LSET;
                start_o      = 1'b1;
              end
            end else if (data_i == CMD_CONFIRM) begin
              if (!supply_ok_i)      err_set_o = ERR_SUPPLY_M | ERR_ERASE_M;
              else if (!unlock_en_i) err_set_o = ERR_LOCK_M | ERR_ERASE_M;
              else begin
                start_kind_o = OP_LCLR;
                start_o      = 1'b1;
              end
            end else begin
              err_set_o = ERR_ERASE_M | ERR_PROG_M;
            end
          end
          default: ;
        endcase
      end else begin
        case (data_i)
          CMD_RD_ARRAY:  if (!running) mode_d = RD_ARRAY;
          CMD_RD_STATUS: mode_d = RD_STATUS;
          CMD_RD_IDENT:  if (!running) mode_d = RD_IDENT;
          CMD_RD_QUERY:  if (!running) mode_d = RD_QUERY;
          CMD_CLR_ERR:   if (idle_all) clr_err_o = 1'b1;
          CMD_PROG_A, CMD_PROG_B:
            if (idle_all || (esusp_i && !nested_active_i)) begin
              pend_d = SU_PROG;
              mode_d = RD_STATUS;
            end
          CMD_ERASE:
            if (idle_all) begin
              pend_d = SU_ERASE;
              mode_d = RD_STATUS;
            end
          CMD_LOCK:
            if (idle_all) begin
              pend_d = SU_LOCK;
              mode_d = RD_STATUS;
            end
          CMD_SUSPEND:
            if (can_susp_i) begin
              susp_req_o = 1'b1;
              mode_d     = RD_STATUS;
            end
          CMD_CONFIRM:
            if (prim_susp_i && !nested_active_i) begin
              resume_req_o = 1'b1;
              mode_d       = RD_STATUS;
            end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RD_ARRAY;
      pend_q <= SU_NONE;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mode_o = mode_q;

  p_array_held_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (pend_q == SU_NONE) && (data_i == CMD_RD_ARRAY) && running) |=> (mode_q == $past(mode_q)));
  p_start_needs_supply_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || start_nested_o) |-> supply_ok_i);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int BLK_W    = 2,
  parameter int CNT_W    = 8,
  parameter int SUSP_LAT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [BLK_W-1:0]      blk_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  supply_ok_i,
  input  logic                  unlock_en_i,
  input  logic [CNT_W-1:0]      op_cycles_i,
  output logic [1:0]            rd_mode_o,
  output logic [7:0]            status_o,
  output logic                  busy_o,
  output logic [(1<<BLK_W)-1:0] lock_o
);
  localparam int NBLK = 1 << BLK_W;

  rd_mode_e         mode;
  op_kind_e         start_kind;
  logic             start, start_nested, susp_req, resume_req, clr_err;
  logic [3:0]       err_set, err_q;
  logic             prim_active, prim_susp, nested_active, esusp, psusp, can_susp;
  logic             lock_set, lock_clr, ready;
  logic [BLK_W-1:0] lock_blk;
  logic [NBLK-1:0]  locks;

  fcc_cmd_decoder #(.BLK_W(BLK_W)) u_dec (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .blk_i(blk_addr_i), .data_i(wr_data_i),
    .supply_ok_i, .unlock_en_i, .lock_i(locks),
    .prim_active_i(prim_active), .prim_susp_i(prim_susp), .nested_active_i(nested_active),
    .esusp_i(esusp), .can_susp_i(can_susp),
    .mode_o(mode), .start_o(start), .start_nested_o(start_nested), .start_kind_o(start_kind),
    .susp_req_o(susp_req), .resume_req_o(resume_req), .clr_err_o(clr_err), .err_set_o(err_set)
  );

  fcc_sequencer #(.BLK_W(BLK_W), .CNT_W(CNT_W), .SUSP_LAT(SUSP_LAT)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .start_nested_i(start_nested), .kind_i(start_kind),
    .blk_i(blk_addr_i), .len_i(op_cycles_i), .susp_req_i(susp_req), .resume_req_i(resume_req),
    .prim_active_o(prim_active), .prim_susp_o(prim_susp), .nested_active_o(nested_active),
    .esusp_o(esusp), .psusp_o(psusp), .can_susp_o(can_susp),
    .lock_set_o(lock_set), .lock_clr_o(lock_clr), .lock_blk_o(lock_blk)
  );

  fcc_lock_bank #(.BLK_W(BLK_W)) u_locks (
    .clk_i, .rst_ni, .set_i(lock_set), .clr_i(lock_clr), .blk_i(lock_blk), .lock_o(locks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= '0;
    else if (clr_err) err_q <= '0;
    else              err_q <= err_q | err_set;
  end

  assign ready     = !((prim_active && !prim_susp) || nested_active);
  assign busy_o    = !ready;
  assign rd_mode_o = mode;
  assign lock_o    = locks;
  assign status_o  = {ready, esusp, err_q[3], err_q[2], err_q[1], psusp, err_q[0], 1'b0};

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(err_q) & ~err_q)) |-> $past(clr_err));
  p_clear_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err |-> (!busy_o && !prim_susp));
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int BLK_W = 2;
  localparam int CNT_W = 8;
  localparam int SLAT  = 2;
  localparam logic [7:0] RDY = 8'h80, ES = 8'h40, EE = 8'h20, PE = 8'h10,
                         VE = 8'h08, PS = 8'h04, LE = 8'h02;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [BLK_W-1:0] blk = '0;
  logic [7:0] data = '0;
  logic supply_ok = 1'b1;
  logic unlock_en = 1'b1;
  logic [CNT_W-1:0] op_cycles = 8'd3;
  logic [1:0] rd_mode;
  logic [7:0] status;
  logic busy;
  logic [3:0] lock;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.BLK_W(BLK_W), .CNT_W(CNT_W), .SUSP_LAT(SLAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .blk_addr_i(blk), .wr_data_i(data),
    .supply_ok_i(supply_ok), .unlock_en_i(unlock_en), .op_cycles_i(op_cycles),
    .rd_mode_o(rd_mode), .status_o(status), .busy_o(busy), .lock_o(lock)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [BLK_W-1:0] b, input logic [7:0] d);
    wr_en = 1'b1; blk = b; data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic wait_ready(input string req, input int max);
    for (int i = 0; i < max; i++) begin
      if (!busy) break;
      idle(1);
    end
    check(req, busy, 0);
  endtask

  function automatic int exp_mode(input int b);
    case (b)
      'hFF: return 0;
      'h70, 'h40, 'h10, 'h20, 'h60: return 1;
      'h98: return 3;
      default: return 2;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 mode", rd_mode, 0);
    check("R1 status", status, RDY);
    check("R1 busy", busy, 0);
    check("R1 locks", lock, 0);

    // R2 / R12 sweep of every first-cycle byte from identifier mode
    for (int b = 0; b < 256; b++) begin
      do_reset();
      wr(0, 8'h90);
      wr(0, b[7:0]);
      check("R2 R12 mode sweep", rd_mode, exp_mode(b));
      check("R12 status sweep", status, RDY);
    end

    // R3 program timing over durations
    for (int n = 1; n <= 6; n++) begin
      do_reset();
      op_cycles = n[7:0];
      wr(n[1:0], (n % 2) ? 8'h40 : 8'h10);
      wr(n[1:0], 8'h5A);
      check("R3 busy at start", busy, 1);
      check("R3 status at start", status, 0);
      check("R3 mode status", rd_mode, 1);
      idle(n - 1);
      check("R3 busy last cycle", busy, 1);
      idle(1);
      check("R3 done", status, RDY);
    end

    // R4 erase and bad confirm
    op_cycles = 4;
    wr(1, 8'h20); wr(1, 8'hD0);
    check("R4 erase busy", busy, 1);
    idle(4);
    check("R4 erase done", status, RDY);
    wr(1, 8'h20); wr(1, 8'hFF);
    check("R4 bad confirm", status, RDY | EE | PE);
    check("R4 no op", busy, 0);
    wr(0, 8'h50);
    check("R8 clear", status, RDY);

    // R5 lock set each block
    op_cycles = 3;
    for (int b = 0; b < 4; b++) begin
      wr(b[1:0], 8'h60); wr(b[1:0], 8'h01);
      check("R5 lock pending", lock, (1 << b) - 1);
      idle(3);
      check("R5 lock set", lock, (1 << (b + 1)) - 1);
    end
    // R7 gating
    unlock_en = 1'b0;
    wr(1, 8'h40); wr(1, 8'hAA);
    check("R7 prog locked", status, RDY | PE | LE);
    check("R7 prog locked busy", busy, 0);
    wr(0, 8'h50);
    wr(2, 8'h20); wr(2, 8'hD0);
    check("R7 erase locked", status, RDY | EE | LE);
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'h01);
    check("R7 set gated", status, RDY | PE | LE);
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'hD0);
    check("R7 clear gated", status, RDY | EE | LE);
    check("R7 locks kept", lock, 4'hF);
    wr(0, 8'h50);
    unlock_en = 1'b1;
    wr(1, 8'h10); wr(1, 8'h5A);
    check("R7 prog unlocked", busy, 1);
    idle(3);
    check("R7 prog unlocked done", status, RDY);
    wr(0, 8'h60); wr(0, 8'hD0);
    idle(3);
    check("R5 clear all", lock, 0);
    check("R5 clear status", status, RDY);
    wr(0, 8'h60); wr(0, 8'h33);
    check("R5 bad lock byte", status, RDY | EE | PE);
    wr(0, 8'h50);

    // R6 supply
    supply_ok = 1'b0;
    wr(0, 8'h40); wr(0, 8'h11);
    check("R6 prog supply", status, RDY | VE | PE);
    wr(0, 8'h50);
    wr(0, 8'h20); wr(0, 8'hD0);
    check("R6 erase supply", status, RDY | VE | EE);
    supply_ok = 1'b1;
    wr(3, 8'h40); wr(3, 8'h01);
    idle(3);
    check("R8 sticky across op", status, RDY | VE | EE);
    wr(0, 8'h50);
    check("R8 cleared", status, RDY);

    // R8 clear ignored while running
    wr(0, 8'h20); wr(0, 8'h07);
    wr(0, 8'h40); wr(0, 8'h01);
    check("R8 running view", status, EE | PE);
    wr(0, 8'h50);
    idle(2);
    check("R8 clear ignored running", status, RDY | EE | PE);
    wr(0, 8'h50);
    check("R8 clear idle", status, RDY);

    // R11 commands ignored while running
    op_cycles = 10;
    wr(0, 8'h40); wr(0, 8'h01);
    wr(0, 8'hFF); check("R11 array refused", rd_mode, 1);
    wr(0, 8'h90); check("R11 ident refused", rd_mode, 1);
    wr(0, 8'h98); check("R11 query refused", rd_mode, 1);
    wr(0, 8'h20); check("R11 setup refused", rd_mode, 1);
    idle(6);
    check("R11 op done", status, RDY);
    wr(0, 8'hFF);
    check("R2 array after op", rd_mode, 0);

    // R9 / R10 erase suspend with nested program
    op_cycles = 40;
    wr(0, 8'h20); wr(0, 8'hD0);
    idle(2);
    wr(0, 8'hB0);
    check("R9 suspend latency", status, 0);
    idle(SLAT - 1);
    check("R9 not yet suspended", status, 0);
    idle(1);
    check("R9 erase suspended", status, RDY | ES);
    wr(0, 8'hFF);
    check("R9 array in suspend", rd_mode, 0);
    wr(0, 8'h70);
    supply_ok = 1'b0;
    wr(2, 8'h40); wr(2, 8'h03);
    check("R6 nested supply", status, RDY | ES | VE | PE);
    supply_ok = 1'b1;
    wr(0, 8'h50);
    check("R8 clear ignored suspend", status, RDY | ES | VE | PE);
    op_cycles = 5;
    wr(2, 8'h40); wr(2, 8'h09);
    check("R10 nested running", status, ES | VE | PE);
    wr(0, 8'hD0);
    check("R10 resume refused", status, ES | VE | PE);
    idle(3);
    check("R10 nested busy", busy, 1);
    idle(1);
    check("R10 nested done", status, RDY | ES | VE | PE);
    wr(0, 8'hD0);
    check("R9 resumed", status, VE | PE);
    wait_ready("R9 erase completes", 80);
    check("R9 final status", status, RDY | VE | PE);
    wr(0, 8'h50);

    // R9 program suspend
    op_cycles = 40;
    wr(1, 8'h40); wr(1, 8'h02);
    idle(1);
    wr(0, 8'hB0);
    idle(SLAT);
    check("R9 program suspended", status, RDY | PS);
    wr(0, 8'h20);
    check("R9 erase setup refused", status, RDY | PS);
    wr(0, 8'hD0);
    check("R9 program resumed", status, 0);
    wait_ready("R9 program completes", 80);
    check("R9 program final", status, RDY);

    // R13 suspend on completion edge
    op_cycles = 5;
    wr(0, 8'h20); wr(0, 8'hD0);
    idle(4);
    wr(0, 8'hB0);
    check("R13 completes", status, RDY);
    idle(SLAT + 2);
    check("R13 no late suspend", status, RDY);
    check("R13 not busy", busy, 0);

    // R1 reset aborts
    op_cycles = 20;
    wr(2, 8'h60); wr(2, 8'h01);
    idle(3);
    do_reset();
    check("R1 abort status", status, RDY);
    check("R1 abort lock", lock, 0);
    check("R1 abort busy", busy, 0);
    check("R1 abort mode", rd_mode, 0);
    wr(1, 8'h40);
    do_reset();
    wr(1, 8'h55);
    check("R1 setup discarded busy", busy, 0);
    check("R1 setup discarded mode", rd_mode, 0);
    check("R1 setup discarded status", status, RDY);

    finished = 1'b1;
    report();
  end
endmodule